// File: doc/BRIEF.md
# Cross-Port Mailbox Interrupt Generator

This block produces the two doorbell interrupts that go with a two-port shared memory. Each port has a 13-bit address and can reach 8K locations. The two highest addresses are set aside as mailboxes. When one port writes its partner's mailbox, the partner's active-low interrupt line goes low. The partner reads that same location to acknowledge, and its interrupt line returns high. The memory array, the data path and the pin timing all sit outside this block. The block only observes each port's enable, direction, output-enable and address lines.

All logic runs on a single clock, and each interrupt output comes from a register. An access seen on a rising edge changes the interrupts one cycle after that edge. Each port has an active-low busy input. While that input is low, every set or clear that the port would cause is suppressed. Two rules settle the remaining cases. If a raise and an acknowledge of the same flag land in the same cycle, the raise wins. Any other access leaves both flags as they were.

Top module: `mbox_irq`

## Requirements
- R1: While synchronous reset is high, both irqLN and irqRN are driven high (1) from the cycle after the reset edge.
- R2: A left-port access with lSelN=0, lRwN=0 and lAddr=0x1FFF, with lBusyN=1, drives irqRN low after the next clock edge.
- R3: A right-port access with rSelN=0, rOeN=0 and rAddr=0x1FFF, with rBusyN=1, drives irqRN high after the next clock edge, whatever the value of rRwN.
- R4: A right-port access with rSelN=0, rRwN=0 and rAddr=0x1FFE, with rBusyN=1, drives irqLN low after the next clock edge.
- R5: A left-port access with lSelN=0, lOeN=0 and lAddr=0x1FFE, with lBusyN=1, drives irqLN high after the next clock edge, whatever the value of lRwN.
- R6: When a port's busy input is 0, any set or clear that port would cause (R2 to R5) does not change the affected interrupt.
- R7: If, in one cycle, one port raises a flag and the other port acknowledges that same flag, the flag ends up set (its interrupt output is low).
- R8: Any access that matches none of R2 to R5 leaves both interrupt outputs unchanged. This covers a deselected port, another address, a port writing its own mailbox with the output enable high, and a port reading its partner's mailbox.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lSelN | input | 1 | Left chip enable, active low |
| lRwN | input | 1 | Left direction, 0 = write |
| lOeN | input | 1 | Left output enable, active low |
| lAddr | input | 13 | Left address |
| lBusyN | input | 1 | Left busy, 0 blocks left-caused updates |
| rSelN | input | 1 | Right chip enable, active low |
| rRwN | input | 1 | Right direction, 0 = write |
| rOeN | input | 1 | Right output enable, active low |
| rAddr | input | 13 | Right address |
| rBusyN | input | 1 | Right busy, 0 blocks right-caused updates |
| irqLN | output | 1 | Interrupt to the left port, active low |
| irqRN | output | 1 | Interrupt to the right port, active low |

## Verification
The assertions assume that every port input is stable and known at each rising edge, and that one edge is one access. No access is stretched across several cycles. The bench drives every input on the falling edge and holds it for a full cycle, so each sampled combination counts as exactly one access. The sweep steps through the enable, direction, output-enable, busy and address combinations on both ports together, including both mailboxes and nearby addresses. The flag state carries over from one step to the next, so set, clear and collision cases are reached from both starting values.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int ADDR_W = 13;
  localparam int PORTS  = 2;
  localparam int LEFT   = 0;
  localparam int RIGHT  = 1;

  typedef struct packed {
    logic setLeft;
    logic clrLeft;
    logic setRight;
    logic clrRight;
  } mboxStrobe_t;
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode #(
  parameter int ADDR_W = 13,
  parameter logic [ADDR_W-1:0] OWN_BOX = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
  input  logic              selN,
  input  logic              rwN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busyN,
  output logic              raisePeer,
  output logic              ackOwn
);
  logic hitOwn;
  logic hitPeer;
  logic active;

  always_comb begin
    hitOwn    = (addr == OWN_BOX);
    hitPeer   = (addr == PEER_BOX);
    active    = ~selN & busyN;
    raisePeer = active & ~rwN & hitPeer;
    ackOwn    = active & ~oeN & hitOwn;
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [PORTS-1:0]  selN,
  input  logic [PORTS-1:0]  rwN,
  input  logic [PORTS-1:0]  oeN,
  input  logic [AW-1:0]     addr [PORTS],
  input  logic [PORTS-1:0]  busyN,
  output mboxStrobe_t       strobe
);
  localparam logic [AW-1:0] RIGHT_BOX = '1;
  localparam logic [AW-1:0] LEFT_BOX  = RIGHT_BOX - 1'b1;

  logic [PORTS-1:0] raisePeer;
  logic [PORTS-1:0] ackOwn;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    localparam logic [AW-1:0] OWNB  = (p == LEFT) ? LEFT_BOX  : RIGHT_BOX;
    localparam logic [AW-1:0] PEERB = (p == LEFT) ? RIGHT_BOX : LEFT_BOX;
    mbox_port_decode #(
      .ADDR_W  (AW),
      .OWN_BOX (OWNB),
      .PEER_BOX(PEERB)
    ) u_dec (
      .selN     (selN[p]),
      .rwN      (rwN[p]),
      .oeN      (oeN[p]),
      .addr     (addr[p]),
      .busyN    (busyN[p]),
      .raisePeer(raisePeer[p]),
      .ackOwn   (ackOwn[p])
    );
  end

  always_comb begin
    strobe.setRight = raisePeer[LEFT];
    strobe.clrRight = ackOwn[RIGHT];
    strobe.setLeft  = raisePeer[RIGHT];
    strobe.clrLeft  = ackOwn[LEFT];
  end
endmodule

// File: rtl/mbox_flags.sv
module mbox_flags
  import mbox_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  mboxStrobe_t strobe,
  output logic        irqLN,
  output logic        irqRN
);
  logic pendLeft;
  logic pendRight;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendLeft  <= 1'b0;
      pendRight <= 1'b0;
    end else begin
      if (strobe.setLeft)       pendLeft <= 1'b1;
      else if (strobe.clrLeft)  pendLeft <= 1'b0;
      if (strobe.setRight)      pendRight <= 1'b1;
      else if (strobe.clrRight) pendRight <= 1'b0;
    end
  end

  assign irqLN = ~pendLeft;
  assign irqRN = ~pendRight;

  // R2 R7
  set_right_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.setRight |=> !irqRN);
  // R4 R7
  set_left_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.setLeft |=> !irqLN);
  // R3
  clr_right_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.clrRight && !strobe.setRight) |=> irqRN);
  // R5
  clr_left_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.clrLeft && !strobe.setLeft) |=> irqLN);
endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lSelN,
  input  logic              lRwN,
  input  logic              lOeN,
  input  logic [ADDR_W-1:0] lAddr,
  input  logic              lBusyN,
  input  logic              rSelN,
  input  logic              rRwN,
  input  logic              rOeN,
  input  logic [ADDR_W-1:0] rAddr,
  input  logic              rBusyN,
  output logic              irqLN,
  output logic              irqRN
);
  localparam logic [ADDR_W-1:0] TOP_BOX = '1;
  localparam logic [ADDR_W-1:0] LOW_BOX = TOP_BOX - 1'b1;

  logic [ADDR_W-1:0] addrVec [PORTS];
  mboxStrobe_t       strobe;

  assign addrVec[LEFT]  = lAddr;
  assign addrVec[RIGHT] = rAddr;

  mbox_ctrl #(.AW(ADDR_W)) u_ctrl (
    .selN  ({rSelN, lSelN}),
    .rwN   ({rRwN, lRwN}),
    .oeN   ({rOeN, lOeN}),
    .addr  (addrVec),
    .busyN ({rBusyN, lBusyN}),
    .strobe(strobe)
  );

  mbox_flags u_flags (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .irqLN (irqLN),
    .irqRN (irqRN)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (irqLN && irqRN));
  // R6
  lbusy_no_raise_chk: assert property (@(posedge clk) disable iff (rst)
    !lBusyN |=> !$fell(irqRN));
  // R6
  rbusy_no_raise_chk: assert property (@(posedge clk) disable iff (rst)
    !rBusyN |=> !$fell(irqLN));
  // R6
  lbusy_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !lBusyN |=> !$rose(irqLN));
  // R6
  rbusy_no_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !rBusyN |=> !$rose(irqRN));
  // R8
  off_box_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (lAddr != TOP_BOX && lAddr != LOW_BOX && rAddr != TOP_BOX && rAddr != LOW_BOX)
      |=> ($stable(irqLN) && $stable(irqRN)));
endmodule

// File: tb/mbox_irq_bench.sv
module mbox_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lSelN = 1'b1, lRwN = 1'b1, lOeN = 1'b1, lBusyN = 1'b1;
  logic rSelN = 1'b1, rRwN = 1'b1, rOeN = 1'b1, rBusyN = 1'b1;
  logic [AW-1:0] lAddr = '0, rAddr = '0;
  logic irqLN, irqRN;

  int checks = 0;
  int errors = 0;
  logic expL = 1'b0, expR = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_irq u_mbox_irq (
    .clk(clk), .rst(rst),
    .lSelN(lSelN), .lRwN(lRwN), .lOeN(lOeN), .lAddr(lAddr), .lBusyN(lBusyN),
    .rSelN(rSelN), .rRwN(rRwN), .rOeN(rOeN), .rAddr(rAddr), .rBusyN(rBusyN),
    .irqLN(irqLN), .irqRN(irqRN)
  );

  function automatic logic [AW-1:0] pickAddr(int k);
    case (k)
      0: return 13'h1FFF;
      1: return 13'h1FFE;
      2: return 13'h1FFD;
      3: return 13'h0000;
      4: return 13'h0FFF;
      default: return 13'h1FFC;
    endcase
  endfunction

  task automatic check(string tag, logic expLN, logic expRN);
    checks++;
    if (irqLN !== expLN || irqRN !== expRN) begin
      errors++;
      $display("FAIL %s irqLN=%b irqRN=%b expected irqLN=%b irqRN=%b",
               tag, irqLN, irqRN, expLN, expRN);
    end
  endtask

  // One access cycle: drive at negedge, compute model, check at next negedge.
  task automatic access(input logic ls, lr, lo, input logic [AW-1:0] la, input logic lb,
                        input logic rs, rr, ro, input logic [AW-1:0] ra, input logic rb,
                        input string forced);
    logic sR, cR, sL, cL, blk;
    string tag;
    lSelN = ls; lRwN = lr; lOeN = lo; lAddr = la; lBusyN = lb;
    rSelN = rs; rRwN = rr; rOeN = ro; rAddr = ra; rBusyN = rb;
    sR = !ls && !lr && la == 13'h1FFF;
    cR = !rs && !ro && ra == 13'h1FFF;
    sL = !rs && !rr && ra == 13'h1FFE;
    cL = !ls && !lo && la == 13'h1FFE;
    blk = ((sR || cL) && !lb) || ((sL || cR) && !rb);
    sR = sR && lb; cL = cL && lb; sL = sL && rb; cR = cR && rb;
    if ((sR && cR) || (sL && cL)) tag = "R7";
    else if (blk) tag = "R6";
    else if (sR) tag = "R2";
    else if (cR) tag = "R3";
    else if (sL) tag = "R4";
    else if (cL) tag = "R5";
    else tag = "R8";
    if (forced != "") tag = forced;
    if (sR) expR = 1'b1; else if (cR) expR = 1'b0;
    if (sL) expL = 1'b1; else if (cL) expL = 1'b0;
    @(negedge clk);
    check(tag, ~expL, ~expR);
  endtask

  task automatic idle();
    access(1,1,1,13'h0000,1, 1,1,1,13'h0000,1, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired irq=%b%b expected run end", irqLN, irqRN);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1", 1'b1, 1'b1);
    rst = 1'b0;
    // Directed: R2 then R3 with rRwN low (don't care)
    access(0,0,1,13'h1FFF,1, 1,1,1,13'h0000,1, "R2");
    idle();
    access(1,1,1,13'h0000,1, 0,0,0,13'h1FFF,1, "R3");
    // R4 then R5 with lRwN high
    access(1,1,1,13'h0000,1, 0,0,1,13'h1FFE,1, "R4");
    access(0,1,0,13'h1FFE,1, 1,1,1,13'h0000,1, "R5");
    // R6: left busy blocks set of right flag
    access(0,0,1,13'h1FFF,0, 1,1,1,13'h0000,1, "R6");
    // R8: left reads right mailbox, no change; right writes own mailbox with oe high
    access(0,0,1,13'h1FFF,1, 1,1,1,13'h0000,1, "R2");
    access(0,1,0,13'h1FFF,1, 0,0,1,13'h1FFF,1, "R8");
    // R6: right busy blocks clear of right flag
    access(1,1,1,13'h0000,1, 0,1,0,13'h1FFF,0, "R6");
    // R7: set and clear same cycle
    access(0,0,1,13'h1FFF,1, 0,1,0,13'h1FFF,1, "R7");
    // Sweep across both ports
    for (int i = 0; i < 96; i++) begin
      for (int j = 0; j < 96; j++) begin
        access(i[3], i[2], i[1], pickAddr(i / 16), i[0],
               j[3], j[2], j[1], pickAddr(j / 16), j[0], "");
      end
    end
    // Reset again mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R1", 1'b1, 1'b1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule